// File: doc/BRIEF.md
# SPI Flash Erase Sequencer

This block is a serial-peripheral-interface master that carries out a whole flash erase from a single start strobe. It first sends a stand-alone write-enable frame and holds chip select high for a short gap. It then sends the erase frame, which is either a one-byte chip erase or a sector erase followed by a three-byte address. After a second chip-select gap it issues a status-read frame. In that frame it keeps clocking status bytes in, under one unbroken chip-select assertion, until the flash reports that it is no longer busy. Chip select then rises and, after a tail gap, a one-cycle done pulse is given.

All frames are built from one shared byte engine, which shifts a byte out on MOSI and a byte in from MISO in SPI mode 0, and from one shared gap timer. The sequencer only chooses the byte to load and whether chip select stays low. SCK is derived from the drive clock, and each SCK half period lasts a parameterised number of drive cycles.

Top module: `flash_erase_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no start, cs_n_o is 1, sck_o is 0, mosi_o is 0 and done_o is 0. A reset in the middle of a sequence returns the block to idle.
- R2: Each sequence begins with a frame holding exactly one byte, the write-enable opcode 0x06.
- R3: With sector_i = 0 the second frame holds exactly one byte, the chip-erase opcode 0xC7.
- R4: With sector_i = 1 the second frame holds exactly four bytes: the opcode 0x20, then address bits 23:16, 15:8 and 7:0.
- R5: Transfers use SPI mode 0. SCK is low whenever cs_n_o is high, MOSI does not change while SCK is high, and bytes go out MSB first.
- R6: Every SCK high phase lasts exactly HALF_DIV drive-clock cycles.
- R7: cs_n_o stays high for exactly IDLE_GAP drive cycles between the write-enable frame and the erase frame, and again between the erase frame and the status frame.
- R8: The third frame starts with 0x05. It then holds status bytes until the first byte whose bit 0 (the last bit received) is 0, and it ends after that byte. Its length is 2 plus the number of busy bytes.
- R9: done_o is a one-cycle pulse. It is raised after cs_n_o has been high for TAIL_GAP drive cycles following the status frame.
- R10: A start strobe received while a sequence is running is ignored. Each accepted start gives exactly three frames and one done pulse.
- R11: sector_i and addr_i are captured when a start is accepted. Changing them later in the sequence has no effect on the frames that are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Drive clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle request to begin an erase sequence |
| sector_i | input | 1 | 1 selects sector erase with address, 0 selects chip erase |
| addr_i | input | 24 | Sector address, captured when a start is accepted |
| miso_i | input | 1 | Serial data from the flash |
| cs_n_o | output | 1 | Active-low chip select |
| sck_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the flash |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The hardest situation to reach is the status-poll exit. It depends on the flash model returning a chosen number of busy bytes and then a ready byte, with the ready bit landing exactly as the eighth bit of a byte inside a frame that is already running. The bench slave model decodes the opcode of the frame in progress and, once it sees 0x05, serves status bytes bit by bit on MISO. The number of busy bytes and the upper status bits are random, with directed runs for zero and several busy bytes. Starts issued in the middle of a run, together with changed mode and address inputs, cover the ignore and capture rules.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_WEN,
    S_GAP1,
    S_ERASE,
    S_ADDR,
    S_GAP2,
    S_POLL_OP,
    S_POLL,
    S_TAIL
  } seq_state_e;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_CHIP  = 8'hC7;
  localparam logic [7:0] OP_SECT  = 8'h20;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_DUMMY = 8'h00;
endpackage

// File: rtl/fes_gap_timer.sv
module fes_gap_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = len_i;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

  AST_GAP_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/fes_byte_engine.sv
module fes_byte_engine #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic [7:0] rx_o,
  output logic       last_o
);
  localparam int DIV_W = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic             busy_q, busy_d;
  logic             sck_q, sck_d;
  logic             mosi_q, mosi_d;
  logic [7:0]       tx_q, tx_d;
  logic [7:0]       rx_q, rx_d;
  logic [2:0]       bit_q, bit_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             div_end;

  assign div_end = (div_q == DIV_LAST);
  assign last_o  = busy_q && sck_q && div_end && (bit_q == 3'd7);

  always_comb begin
    busy_d = busy_q;
    sck_d  = sck_q;
    mosi_d = mosi_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    bit_d  = bit_q;
    div_d  = div_q;
    if (go_i) begin
      busy_d = 1'b1;
      sck_d  = 1'b0;
      mosi_d = tx_i[7];
      tx_d   = {tx_i[6:0], 1'b0};
      bit_d  = '0;
      div_d  = '0;
    end else if (busy_q) begin
      if (div_end) begin
        div_d = '0;
        if (!sck_q) begin
          sck_d = 1'b1;
          rx_d  = {rx_q[6:0], miso_i};
        end else begin
          sck_d = 1'b0;
          if (bit_q == 3'd7) begin
            busy_d = 1'b0;
            mosi_d = 1'b0;
          end else begin
            bit_d  = bit_q + 1'b1;
            mosi_d = tx_q[7];
            tx_d   = {tx_q[6:0], 1'b0};
          end
        end
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      div_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sck_q  <= sck_d;
      mosi_q <= mosi_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      bit_q  <= bit_d;
      div_q  <= div_d;
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = mosi_q;
  assign rx_o   = rx_q;

  AST_MOSI_HELD_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && $past(sck_q)) |-> $stable(mosi_q)); // R5
  AST_SCK_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck_q); // R5
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int IDLE_GAP = 3,
  parameter int TAIL_GAP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        sector_i,
  input  logic [23:0] addr_i,
  input  logic        miso_i,
  output logic        cs_n_o,
  output logic        sck_o,
  output logic        mosi_o,
  output logic        done_o
);
  localparam int GAP_MAX = (IDLE_GAP > TAIL_GAP) ? IDLE_GAP : TAIL_GAP;
  localparam int GCW     = $clog2(GAP_MAX + 1);
  localparam logic [GCW-1:0] IDLE_LEN = GCW'(IDLE_GAP - 1);
  localparam logic [GCW-1:0] TAIL_LEN = GCW'(TAIL_GAP - 1);

  logic [1:0] rst_sync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  seq_state_e state_q, state_d;
  logic        cs_n_q, cs_n_d;
  logic        done_q, done_d;
  logic        sect_q, sect_d;
  logic [23:0] addr_q, addr_d;
  logic [1:0]  aidx_q, aidx_d;

  logic           go;
  logic [7:0]     tx_byte;
  logic           gap_load;
  logic [GCW-1:0] gap_len;
  logic           gap_done;
  logic           byte_last;
  logic [7:0]     rx_byte;

  fes_byte_engine #(.HALF_DIV(HALF_DIV)) u_engine (
    .clk    (clk),
    .rst_n  (rst_ns),
    .go_i   (go),
    .tx_i   (tx_byte),
    .miso_i (miso_i),
    .sck_o  (sck_o),
    .mosi_o (mosi_o),
    .rx_o   (rx_byte),
    .last_o (byte_last)
  );

  fes_gap_timer #(.CW(GCW)) u_gap (
    .clk       (clk),
    .rst_n     (rst_ns),
    .load_i    (gap_load),
    .len_i     (gap_len),
    .expired_o (gap_done)
  );

  always_comb begin
    state_d  = state_q;
    cs_n_d   = cs_n_q;
    done_d   = 1'b0;
    sect_d   = sect_q;
    addr_d   = addr_q;
    aidx_d   = aidx_q;
    go       = 1'b0;
    tx_byte  = OP_DUMMY;
    gap_load = 1'b0;
    gap_len  = IDLE_LEN;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          sect_d  = sector_i;
          addr_d  = addr_i;
          cs_n_d  = 1'b0;
          go      = 1'b1;
          tx_byte = OP_WREN;
          state_d = S_WEN;
        end
      end
      S_WEN: begin
        if (byte_last) begin
          cs_n_d   = 1'b1;
          gap_load = 1'b1;
          state_d  = S_GAP1;
        end
      end
      S_GAP1: begin
        if (gap_done) begin
          cs_n_d  = 1'b0;
          go      = 1'b1;
          tx_byte = sect_q ? OP_SECT : OP_CHIP;
          aidx_d  = 2'd0;
          state_d = S_ERASE;
        end
      end
      S_ERASE: begin
        if (byte_last) begin
          if (sect_q) begin
            go      = 1'b1;
            tx_byte = addr_q[23:16];
            aidx_d  = 2'd1;
            state_d = S_ADDR;
          end else begin
            cs_n_d   = 1'b1;
            gap_load = 1'b1;
            state_d  = S_GAP2;
          end
        end
      end
      S_ADDR: begin
        if (byte_last) begin
          if (aidx_q == 2'd3) begin
            cs_n_d   = 1'b1;
            gap_load = 1'b1;
            state_d  = S_GAP2;
          end else begin
            go      = 1'b1;
            tx_byte = (aidx_q == 2'd1) ? addr_q[15:8] : addr_q[7:0];
            aidx_d  = aidx_q + 1'b1;
          end
        end
      end
      S_GAP2: begin
        if (gap_done) begin
          cs_n_d  = 1'b0;
          go      = 1'b1;
          tx_byte = OP_RDSR;
          state_d = S_POLL_OP;
        end
      end
      S_POLL_OP: begin
        if (byte_last) begin
          go      = 1'b1;
          state_d = S_POLL;
        end
      end
      S_POLL: begin
        if (byte_last) begin
          if (!rx_byte[0]) begin
            cs_n_d   = 1'b1;
            gap_load = 1'b1;
            gap_len  = TAIL_LEN;
            state_d  = S_TAIL;
          end else begin
            go = 1'b1;
          end
        end
      end
      S_TAIL: begin
        if (gap_done) begin
          done_d  = 1'b1;
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= S_IDLE;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
      sect_q  <= 1'b0;
      addr_q  <= '0;
      aidx_q  <= '0;
    end else begin
      state_q <= state_d;
      cs_n_q  <= cs_n_d;
      done_q  <= done_d;
      sect_q  <= sect_d;
      addr_q  <= addr_d;
      aidx_q  <= aidx_d;
    end
  end

  assign cs_n_o = cs_n_q;
  assign done_o = done_q;

  AST_SCK_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_ns)
    cs_n_q |-> !sck_o); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_ns)
    done_q |=> !done_q); // R9
  AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_ns)
    done_q |-> (cs_n_q && !sck_o)); // R9
  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q != S_IDLE) |=> ($stable(addr_q) && $stable(sect_q))); // R11
  AST_CS_LOW_IN_POLL: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == S_POLL && !byte_last) |=> !cs_n_q); // R8
endmodule

// File: tb/flash_erase_seq_tb_top.sv
`timescale 1ns/1ps
module flash_erase_seq_tb_top;
  localparam int HALF_DIV = 2;
  localparam int IDLE_GAP = 3;
  localparam int TAIL_GAP = 4;

  logic clk, rst_n, start, sector, miso;
  logic [23:0] addr;
  logic cs_n, sck, mosi, done;

  int n_chk, n_err, cyc;

  flash_erase_seq #(.HALF_DIV(HALF_DIV), .IDLE_GAP(IDLE_GAP), .TAIL_GAP(TAIL_GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .sector_i(sector), .addr_i(addr),
    .miso_i(miso), .cs_n_o(cs_n), .sck_o(sck), .mosi_o(mosi), .done_o(done));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // slave model / monitor state
  logic       mon_clr;
  logic       prev_sck, prev_cs, prev_mosi, prev_done;
  logic [7:0] cur;
  int         fbits, nfr, ngap, gap_run, hi_run, done_cnt, tail_seen;
  int         r5_err, r6_err, r9_err;
  int         frame_len [0:5];
  logic [7:0] frame_b   [0:5][0:15];
  int         gaps      [0:5];
  int         stat_busy;
  logic [7:0] stat_pat;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mon_clr) begin
      nfr = 0; ngap = 0; fbits = 0; gap_run = 0; hi_run = 0; done_cnt = 0;
      tail_seen = 0; r5_err = 0; r6_err = 0; r9_err = 0;
      for (int i = 0; i < 6; i++) begin frame_len[i] = 0; gaps[i] = 0; end
    end else begin
      if (!cs_n) begin
        if (prev_cs) begin
          fbits = 0;
          if (nfr > 0 && ngap < 6) begin gaps[ngap] = gap_run; ngap++; end
        end
        if (sck && !prev_sck) begin
          cur = {cur[6:0], mosi};
          fbits++;
          if (fbits % 8 == 0 && nfr < 6 && fbits / 8 <= 16) frame_b[nfr][fbits/8-1] = cur;
        end
      end else begin
        if (!prev_cs) begin
          if (nfr < 6) frame_len[nfr] = fbits / 8;
          nfr++;
          gap_run = 0;
        end
        gap_run++;
        if (sck) r5_err++;
      end
      if (sck) hi_run++;
      else begin
        if (prev_sck && hi_run != HALF_DIV) r6_err++;
        hi_run = 0;
      end
      if (sck && prev_sck && mosi != prev_mosi) r5_err++;
      if (done) begin
        done_cnt++;
        tail_seen = gap_run;
        if (prev_done) r9_err++;
      end
    end
    // MISO drive for status frame
    miso = 1'b1;
    if (!cs_n && fbits >= 8 && nfr < 6) begin
      if (frame_b[nfr][0] == 8'h05) begin
        automatic int s = fbits / 8 - 1;
        automatic logic [7:0] v = {stat_pat[7:1], (s < stat_busy) ? 1'b1 : 1'b0};
        miso = v[7 - (fbits % 8)];
      end
    end
    prev_sck = sck; prev_cs = cs_n; prev_mosi = mosi; prev_done = done;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk); mon_clr = 1'b1;
    @(posedge clk); mon_clr = 1'b0;
  endtask

  task automatic pulse_start(input logic md, input logic [23:0] a);
    @(negedge clk); start = 1'b1; sector = md; addr = a;
    @(negedge clk); start = 1'b0;
  endtask

  // expected erase-frame byte k
  function automatic logic [7:0] exp_erase(input logic md, input logic [23:0] a, input int k);
    if (k == 0) return md ? 8'h20 : 8'hC7;
    return a[23 - 8*(k-1) -: 8];
  endfunction

  task automatic run_seq(input logic md, input logic [23:0] a, input int busy_n,
                         input logic [7:0] pat, input bit disturb);
    int w;
    stat_busy = busy_n; stat_pat = pat;
    clear_mon();
    pulse_start(md, a);
    if (disturb) begin
      repeat (40) @(negedge clk);
      pulse_start(~md, ~a);          // R10: ignored start with new inputs (R11)
      sector = ~md; addr = ~a;
    end
    w = 0;
    while (done_cnt == 0 && w < 6000) begin @(negedge clk); w++; end
    repeat (60) @(negedge clk);
    chk(w < 6000, "R9 done seen", w, 0);
    chk(done_cnt == 1, "R10 done count", done_cnt, 1);
    chk(nfr == 3, "R10 frame count", nfr, 3);
    chk(frame_len[0] == 1 && frame_b[0][0] == 8'h06, "R2 wren frame", frame_b[0][0], 8'h06);
    if (md) begin
      chk(frame_len[1] == 4, "R4 sector frame length", frame_len[1], 4);
      for (int k = 0; k < 4; k++)
        chk(frame_b[1][k] == exp_erase(1'b1, a, k), "R4 R11 sector byte", frame_b[1][k], exp_erase(1'b1, a, k));
    end else begin
      chk(frame_len[1] == 1 && frame_b[1][0] == 8'hC7, "R3 R11 chip frame", frame_b[1][0], 8'hC7);
    end
    chk(frame_b[2][0] == 8'h05, "R8 status opcode", frame_b[2][0], 8'h05);
    chk(frame_len[2] == busy_n + 2, "R8 status frame length", frame_len[2], busy_n + 2);
    chk(ngap == 2 && gaps[0] == IDLE_GAP && gaps[1] == IDLE_GAP, "R7 cs gaps", gaps[0]*100 + gaps[1], IDLE_GAP*101);
    chk(tail_seen == TAIL_GAP + 1 && r9_err == 0, "R9 tail gap", tail_seen, TAIL_GAP + 1);
    chk(r5_err == 0, "R5 mode0 rules", r5_err, 0);
    chk(r6_err == 0, "R6 sck high width", r6_err, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    n_chk = 0; n_err = 0; cyc = 0;
    mon_clr = 1'b0; start = 1'b0; sector = 1'b0; addr = '0;
    prev_sck = 0; prev_cs = 1; prev_mosi = 0; prev_done = 0; cur = '0;
    nfr = 0; fbits = 0; stat_busy = 0; stat_pat = 8'hFF; miso = 1'b1;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(cs_n && !sck && !mosi && !done, "R1 reset outputs", {cs_n, sck, mosi, done}, 4'b1000);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(cs_n && !sck && !mosi && !done, "R1 idle outputs", {cs_n, sck, mosi, done}, 4'b1000);

    run_seq(1'b0, 24'h000000, 0, 8'h80, 1'b0);
    run_seq(1'b1, 24'hFFFFFF, 0, 8'hFE, 1'b0);
    run_seq(1'b1, 24'h000001, 3, 8'h02, 1'b0);
    run_seq(1'b1, 24'hA5C30F, 2, 8'h5A, 1'b1);
    run_seq(1'b0, 24'h123456, 5, 8'hFF, 1'b1);

    // R1: reset mid-sequence returns to idle
    pulse_start(1'b1, 24'h00FF00);
    repeat (70) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(cs_n && !sck && !mosi && !done, "R1 mid reset outputs", {cs_n, sck, mosi, done}, 4'b1000);
    rst_n = 1'b1;
    repeat (200) @(negedge clk);
    chk(cs_n && !sck && !done, "R1 stays idle after reset", {cs_n, sck, done}, 3'b100);

    for (int i = 0; i < 14; i++) begin
      automatic logic md = 1'($urandom_range(0, 1));
      automatic logic [23:0] a = 24'($urandom());
      automatic int b = $urandom_range(0, 9);
      automatic logic [7:0] p = 8'($urandom());
      run_seq(md, a, b, p, (i % 4) == 3);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule